// File: doc/BRIEF.md
# Three-Operand Integer Adder Unit

This execution unit adds three 32-bit operands under control of a 64-bit instruction word. Register reads, constant fetch and immediate extraction happen upstream, so the operands arrive as plain values. A flag tells the unit whether the instruction uses the register-operand form, the only form that carries shift and half-word controls. The unit decodes the destination index and the control bits. It conditions each operand by optional half-word selection and two's-complement negation. It then forms A+B, adds the incoming carry in extended mode, and can move that partial sum up or down by 16 bits before C is added.

The result, destination index and write strobe appear one cycle after a valid input, qualified by an output valid. The zero, sign, carry and overflow flags are state inside the unit. They change only when the instruction asks for a flag write. Combinations that the unit cannot compute are reported on an illegal-instruction output; no result is written for them.

Top module: `tri_add_unit`

## Requirements
- R1: A legal instruction writes its result to the destination index taken from instruction bits 7:0, with `wr_en` high for that one output cycle.
- R2: In register form, the 2-bit half codes for A (bits 36:35), B (bits 34:33) and C (bits 32:31) mean: 0 takes the full word, 1 takes bits 15:0 zero-extended, and 2 takes bits 31:16 zero-extended.
- R3: Bit 51 negates A, bit 50 negates B and bit 49 negates C (two's complement). Each negation is applied after that operand's half selection.
- R4: With extended mode (bit 48) set, the `carry_in` value is added to A+B before the shift and before C is added.
- R5: Shift code 1 (bits 38:37) replaces the partial sum with the 33-bit A+B shifted right by 16. The carry out of A+B therefore appears at bit 16.
- R6: Shift code 2 shifts the partial sum left by 16 and fills with zeros. Shift code 0 leaves it unchanged.
- R7: When `reg_form` is low, bits 38:31 are ignored, and the instruction behaves as shift code 0 with all half codes 0.
- R8: When the flag-write bit (47) is set on a legal instruction, the zero, sign and carry flags take the zero test, bit 31 and the carry out of the final addition of C.
- R9: On such a write, overflow is the signed overflow of the final addition ORed with (A+B partial sum < conditioned A) compared unsigned.
- R10: The flags keep their values across instructions with bit 47 clear, across illegal instructions and across idle cycles.
- R11: The instruction is illegal when extended mode is combined with shift code 1 or with a flag write, or when register form carries shift code 3 or any half code 3. In that case `illegal` is high, `wr_en` is low and `result` is 0.
- R12: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. After reset, `out_valid`, `wr_en`, `illegal` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 64 | Instruction word |
| reg_form | input | 1 | Instruction is the register-operand form |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| opnd_c | input | 32 | Operand C |
| carry_in | input | 1 | Carry flag used in extended mode |
| out_valid | output | 1 | Output fields are valid |
| result | output | 32 | Sum |
| dest_idx | output | 8 | Destination register index |
| wr_en | output | 1 | Result is to be written |
| illegal | output | 1 | Instruction could not be executed |
| flag_zero | output | 1 | Zero flag |
| flag_sign | output | 1 | Sign flag |
| flag_carry | output | 1 | Carry flag |
| flag_ovf | output | 1 | Overflow flag |

## Verification
The main sweep tries every negate mask, every legal shift code and every legal half code with six operand sets. The sets are all-zero, all-ones, sign-boundary values, mixed bit patterns, half-word-edge values, and a value one step below signed overflow. Mistakes in half order, in negation order and in losing the A+B carry on the right shift each give different results on these sets. The boundary sets also separate the two sources of overflow and the carry of the final add. Directed runs combine extended mode with carry 0 and 1. They send instructions with the flag-write bit clear and reserved or forbidden codes, and check that the flags stay frozen. They also send non-register forms with junk in the control bits, which must still give a plain three-way sum.

// File: rtl/tri_add_pkg.sv
// Shared definitions for the three-operand adder unit.
// Holds the instruction field positions and the decoded control record.
package tri_add_pkg;

    localparam int CC_BIT     = 47;
    localparam int EXT_BIT    = 48;
    localparam int NEG_A_BIT  = 51;  // B and C follow at descending bits
    localparam int SHIFT_LSB  = 37;
    localparam int HALF_A_LSB = 35;  // B and C follow two bits lower each
    localparam int N_OPND     = 3;

    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_LEFT  = 2'd2,
        SH_RSVD  = 2'd3
    } shift_e;

    typedef enum logic [1:0] {
        HALF_FULL = 2'd0,
        HALF_LO   = 2'd1,
        HALF_HI   = 2'd2,
        HALF_RSVD = 2'd3
    } half_e;

    typedef struct packed {
        logic                        cc;
        logic                        ext;
        logic [N_OPND-1:0]           neg;   // index 0 = A, 1 = B, 2 = C
        logic [1:0]                  shift;
        logic [N_OPND-1:0][1:0]      half;  // index 0 = A, 1 = B, 2 = C
        logic                        illegal;
    } ctrl_t;

endpackage

// File: rtl/tri_add_decode.sv
// Instruction field decoder.
// Extracts the control bits and flags illegal combinations.
// Assumes the instruction word is stable while in_valid is high.
module tri_add_decode
    import tri_add_pkg::*;
#(
    parameter int INSN_W = 64
) (
    input  logic [INSN_W-1:0] instr,
    input  logic              reg_form,
    output ctrl_t             ctrl
);

    logic any_rsvd_half;

    // Pull fields; non-register forms see shift 0 and full halves.
    always_comb begin
        ctrl         = '0;
        ctrl.cc      = instr[CC_BIT];
        ctrl.ext     = instr[EXT_BIT];
        for (int i = 0; i < N_OPND; i++) begin
            ctrl.neg[i]  = instr[NEG_A_BIT - i];
            ctrl.half[i] = reg_form ? instr[HALF_A_LSB - 2*i +: 2] : HALF_FULL;
        end
        ctrl.shift   = reg_form ? instr[SHIFT_LSB +: 2] : SH_NONE;
        ctrl.illegal = 1'b0;
        ctrl.illegal = (ctrl.ext && (ctrl.shift == SH_RIGHT))
                     || (ctrl.ext && ctrl.cc)
                     || (ctrl.shift == SH_RSVD)
                     || any_rsvd_half;
    end

    // Detect a reserved half code on any operand.
    always_comb begin
        any_rsvd_half = 1'b0;
        for (int i = 0; i < N_OPND; i++) begin
            if (reg_form && (instr[HALF_A_LSB - 2*i +: 2] == HALF_RSVD)) begin
                any_rsvd_half = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tri_add_operand.sv
// Operand conditioner: half-word pick, then optional two's-complement negate.
// Assumes the reserved half code has been trapped by the decoder.
module tri_add_operand
    import tri_add_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [1:0]        half_sel,
    input  logic              neg,
    output logic [DATA_W-1:0] value
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] picked;

    // Choose the whole word or one zero-extended half.
    always_comb begin
        case (half_sel)
            HALF_LO: picked = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
            HALF_HI: picked = {{HALF_W{1'b0}}, raw[DATA_W-1:HALF_W]};
            default: picked = raw;
        endcase
    end

    // Negate after the half pick.
    always_comb begin
        value = neg ? (~picked + {{(DATA_W-1){1'b0}}, 1'b1}) : picked;
    end

endmodule

// File: rtl/tri_add_core.sv
// Arithmetic core: A+B (+carry), shift of the partial sum, add C, flags.
// Assumes operands are already conditioned; illegal cases are masked by the caller.
module tri_add_core
    import tri_add_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] op_c,
    input  logic              ext,
    input  logic              carry_in,
    input  logic [1:0]        shift,
    output logic [DATA_W-1:0] sum,
    output logic              z,
    output logic              s,
    output logic              c,
    output logic              o
);

    localparam int SH_AMT = DATA_W / 2;
    localparam logic [DATA_W-1:0] FIXUP = DATA_W'(1) << SH_AMT;

    logic [DATA_W:0]   ab_wide;
    logic [DATA_W-1:0] part;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W:0]   fin_wide;
    logic              fin_ovf;

    // First stage: A+B with optional carry in.
    always_comb begin
        ab_wide = {1'b0, op_a} + {1'b0, op_b};
        part    = ab_wide[DATA_W-1:0] + {{(DATA_W-1){1'b0}}, ext & carry_in};
    end

    // Shift stage with recovery of the A+B carry for right shifts.
    always_comb begin
        case (shift)
            SH_RIGHT: shifted = (part >> SH_AMT) + (ab_wide[DATA_W] ? FIXUP : '0);
            SH_LEFT:  shifted = part << SH_AMT;
            default:  shifted = part;
        endcase
    end

    // Final addition and flags.
    always_comb begin
        fin_wide = {1'b0, shifted} + {1'b0, op_c};
        sum      = fin_wide[DATA_W-1:0];
        fin_ovf  = (shifted[DATA_W-1] == op_c[DATA_W-1])
                && (sum[DATA_W-1] != op_c[DATA_W-1]);
        z        = (sum == '0);
        s        = sum[DATA_W-1];
        c        = fin_wide[DATA_W];
        o        = fin_ovf || (part < op_a);
    end

endmodule

// File: rtl/tri_add_unit.sv
// Top of the three-operand adder unit.
// Decodes, conditions operands, adds, and registers outputs one cycle later.
// Holds the four condition flags as state; assumes resolved operands at input.
module tri_add_unit
    import tri_add_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int INSN_W = 64,
    parameter int DEST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] instr,
    input  logic              reg_form,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] opnd_c,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [DEST_W-1:0] dest_idx,
    output logic              wr_en,
    output logic              illegal,
    output logic              flag_zero,
    output logic              flag_sign,
    output logic              flag_carry,
    output logic              flag_ovf
);

    ctrl_t                          ctrl;
    logic [N_OPND-1:0][DATA_W-1:0]  raw_arr;
    logic [N_OPND-1:0][DATA_W-1:0]  cond_arr;
    logic [DATA_W-1:0]              core_sum;
    logic                           core_z, core_s, core_c, core_o;

    tri_add_decode #(.INSN_W(INSN_W)) u_decode (
        .instr    (instr),
        .reg_form (reg_form),
        .ctrl     (ctrl)
    );

    // Gather operands for the conditioning array.
    always_comb begin
        raw_arr[0] = opnd_a;
        raw_arr[1] = opnd_b;
        raw_arr[2] = opnd_c;
    end

    for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
        tri_add_operand #(.DATA_W(DATA_W)) u_opnd (
            .raw      (raw_arr[i]),
            .half_sel (ctrl.half[i]),
            .neg      (ctrl.neg[i]),
            .value    (cond_arr[i])
        );
    end

    tri_add_core #(.DATA_W(DATA_W)) u_core (
        .op_a     (cond_arr[0]),
        .op_b     (cond_arr[1]),
        .op_c     (cond_arr[2]),
        .ext      (ctrl.ext),
        .carry_in (carry_in),
        .shift    (ctrl.shift),
        .sum      (core_sum),
        .z        (core_z),
        .s        (core_s),
        .c        (core_c),
        .o        (core_o)
    );

    // Output stage: register result and strobes one cycle after valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            dest_idx  <= '0;
            wr_en     <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid && !ctrl.illegal;
            illegal   <= in_valid && ctrl.illegal;
            if (in_valid) begin
                dest_idx <= instr[DEST_W-1:0];
                result   <= ctrl.illegal ? '0 : core_sum;
            end
        end
    end

    // Flag state: written only by a legal instruction that asks for it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_zero  <= 1'b0;
            flag_sign  <= 1'b0;
            flag_carry <= 1'b0;
            flag_ovf   <= 1'b0;
        end else if (in_valid && ctrl.cc && !ctrl.illegal) begin
            flag_zero  <= core_z;
            flag_sign  <= core_s;
            flag_carry <= core_c;
            flag_ovf   <= core_o;
        end
    end

endmodule

// File: rtl/tri_add_checker.sv
// Protocol and state checks for the three-operand adder unit, bound to the top.
module tri_add_checker
    import tri_add_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int INSN_W = 64,
    parameter int DEST_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [INSN_W-1:0] instr,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic [DEST_W-1:0] dest_idx,
    input logic              wr_en,
    input logic              illegal,
    input logic              flag_zero,
    input logic              flag_sign,
    input logic              flag_carry,
    input logic              flag_ovf
);

    logic [3:0] flags;
    assign flags = {flag_zero, flag_sign, flag_carry, flag_ovf};

    assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_spurious_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (wr_en != illegal));

    assert_ext_cc_trap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(instr[EXT_BIT]) && $past(instr[CC_BIT])) |-> illegal);

    assert_dest_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && wr_en) |-> (dest_idx == $past(instr[DEST_W-1:0])));

    assert_zero_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && wr_en && $past(instr[CC_BIT]))
        |-> (flag_zero == (result == '0)) && (flag_sign == result[DATA_W-1]));

    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || illegal || !$past(instr[CC_BIT])) |-> (flags == $past(flags)));

endmodule

bind tri_add_unit tri_add_checker #(
    .DATA_W (DATA_W),
    .INSN_W (INSN_W),
    .DEST_W (DEST_W)
) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .instr      (instr),
    .out_valid  (out_valid),
    .result     (result),
    .dest_idx   (dest_idx),
    .wr_en      (wr_en),
    .illegal    (illegal),
    .flag_zero  (flag_zero),
    .flag_sign  (flag_sign),
    .flag_carry (flag_carry),
    .flag_ovf   (flag_ovf)
);

// File: tb/tri_add_unit_test.sv
// Self-checking bench: sweeps controls over operand sets against an arithmetic model.
module tri_add_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] instr = '0;
    logic        reg_form = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
    logic        carry_in = 1'b0;
    logic        out_valid, wr_en, illegal;
    logic [31:0] result;
    logic [7:0]  dest_idx;
    logic        flag_zero, flag_sign, flag_carry, flag_ovf;

    int n_cmp = 0;
    int n_bad = 0;
    logic e_z = 0, e_s = 0, e_c = 0, e_o = 0;

    always #5 clk = ~clk;

    tri_add_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .reg_form(reg_form), .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .carry_in(carry_in), .out_valid(out_valid), .result(result),
        .dest_idx(dest_idx), .wr_en(wr_en), .illegal(illegal),
        .flag_zero(flag_zero), .flag_sign(flag_sign), .flag_carry(flag_carry),
        .flag_ovf(flag_ovf)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [7:0] dst, input logic cc, input logic x,
                                       input logic [2:0] neg_abc, input logic [1:0] sh,
                                       input logic [1:0] ha, input logic [1:0] hb,
                                       input logic [1:0] hc);
        logic [63:0] w = '0;
        w[7:0]   = dst;
        w[47]    = cc;
        w[48]    = x;
        w[51]    = neg_abc[2];
        w[50]    = neg_abc[1];
        w[49]    = neg_abc[0];
        w[38:37] = sh;
        w[36:35] = ha;
        w[34:33] = hb;
        w[32:31] = hc;
        return w;
    endfunction

    function automatic logic [31:0] pick(input logic [31:0] v, input logic [1:0] h);
        case (h)
            2'd1:    return v % 32'd65536;
            2'd2:    return v / 32'd65536;
            default: return v;
        endcase
    endfunction

    task automatic model(input logic [63:0] ins, input logic freg, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] c, input logic cin,
                         output logic ill, output logic [31:0] res, output logic z,
                         output logic s, output logic cy, output logic o);
        logic [1:0] sh, ha, hb, hc;
        logic [31:0] va, vb, vc, l1, l2;
        logic [32:0] s1, f;
        sh = freg ? ins[38:37] : 2'd0;
        ha = freg ? ins[36:35] : 2'd0;
        hb = freg ? ins[34:33] : 2'd0;
        hc = freg ? ins[32:31] : 2'd0;
        ill = (ins[48] && sh == 2'd1) || (ins[48] && ins[47]) || sh == 2'd3
              || ha == 2'd3 || hb == 2'd3 || hc == 2'd3;
        va = pick(a, ha); if (ins[51]) va = 32'd0 - va;
        vb = pick(b, hb); if (ins[50]) vb = 32'd0 - vb;
        vc = pick(c, hc); if (ins[49]) vc = 32'd0 - vc;
        s1 = {1'b0, va} + {1'b0, vb};
        l1 = s1[31:0] + ((ins[48] && cin) ? 32'd1 : 32'd0);
        case (sh)
            2'd1:    l2 = 32'(s1 >> 16);
            2'd2:    l2 = l1 * 32'd65536;
            default: l2 = l1;
        endcase
        f   = {1'b0, l2} + {1'b0, vc};
        res = f[31:0];
        z   = (res == 32'd0);
        s   = res[31];
        cy  = f[32];
        o   = ((l2[31] == vc[31]) && (res[31] != vc[31])) || (l1 < va);
        if (ill) res = 32'd0;
    endtask

    task automatic do_op(input logic [63:0] ins, input logic freg, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] c, input logic cin,
                         input string rtag);
        logic ill, z, s, cy, o;
        logic [31:0] er;
        model(ins, freg, a, b, c, cin, ill, er, z, s, cy, o);
        @(negedge clk);
        instr = ins; reg_form = freg; opnd_a = a; opnd_b = b; opnd_c = c;
        carry_in = cin; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R12 out_valid", {63'd0, out_valid}, 64'd1);
        chk("R11 illegal", {63'd0, illegal}, {63'd0, ill});
        chk("R11 wr_en", {63'd0, wr_en}, {63'd0, !ill});
        if (!ill) begin
            chk("R1 dest", {56'd0, dest_idx}, {56'd0, ins[7:0]});
            chk(rtag, {32'd0, result}, {32'd0, er});
        end else begin
            chk("R11 result", {32'd0, result}, 64'd0);
        end
        if (!ill && ins[47]) begin
            e_z = z; e_s = s; e_c = cy; e_o = o;
            chk("R8 zsc", {61'd0, flag_zero, flag_sign, flag_carry}, {61'd0, e_z, e_s, e_c});
            chk("R9 ovf", {63'd0, flag_ovf}, {63'd0, e_o});
        end else begin
            chk("R10 hold", {60'd0, flag_zero, flag_sign, flag_carry, flag_ovf},
                {60'd0, e_z, e_s, e_c, e_o});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] sa [6];
        logic [31:0] sb [6];
        logic [31:0] sc [6];
        sa[0] = 32'h0;        sb[0] = 32'h0;        sc[0] = 32'h0;
        sa[1] = 32'hffffffff; sb[1] = 32'h1;        sc[1] = 32'h5;
        sa[2] = 32'h80000000; sb[2] = 32'h80000000; sc[2] = 32'h7fffffff;
        sa[3] = 32'h12345678; sb[3] = 32'h9abcdef0; sc[3] = 32'h0f0f0f0f;
        sa[4] = 32'h0000ffff; sb[4] = 32'h0000ffff; sc[4] = 32'hffff0000;
        sa[5] = 32'h7fffffff; sb[5] = 32'h1;        sc[5] = 32'h0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12 reset strobes", {61'd0, out_valid, wr_en, illegal}, 64'd0);
        chk("R12 reset flags", {60'd0, flag_zero, flag_sign, flag_carry, flag_ovf}, 64'd0);

        // R2: directed half picks
        do_op(mk(8'h11, 1'b0, 1'b0, 3'b000, 2'd0, 2'd1, 2'd2, 2'd0), 1'b1,
              32'habcd1234, 32'h56789abc, 32'h1, 1'b0, "R2 half lo/hi");
        do_op(mk(8'h12, 1'b0, 1'b0, 3'b000, 2'd0, 2'd2, 2'd1, 2'd2), 1'b1,
              32'hffff0001, 32'h0002ffff, 32'h80000000, 1'b0, "R2 half zero-ext");

        // Main sweep: negation, shifts, halves over operand sets (R3, R5, R6, R8, R9)
        for (int k = 0; k < 6; k++) begin
            for (int n = 0; n < 8; n++) begin
                for (int sh = 0; sh < 3; sh++) begin
                    for (int h = 0; h < 27; h++) begin
                        do_op(mk(8'(n * 31 + h), 1'b1, 1'b0, 3'(n), 2'(sh),
                                 2'(h % 3), 2'((h / 3) % 3), 2'(h / 9)), 1'b1,
                              sa[k], sb[k], sc[k], 1'b0,
                              (sh == 1) ? "R5 right" : (sh == 2) ? "R6 left" : "R3 negate");
                    end
                end
            end
        end

        // R4: extended mode with carry 0/1, no flag write (R10 hold)
        for (int k = 0; k < 6; k++) begin
            for (int ci = 0; ci < 2; ci++) begin
                do_op(mk(8'h40, 1'b0, 1'b1, 3'b000, 2'd0, 2'd0, 2'd0, 2'd0), 1'b1,
                      sa[k], sb[k], sc[k], 1'(ci), "R4 ext none");
                do_op(mk(8'h41, 1'b0, 1'b1, 3'b101, 2'd2, 2'd1, 2'd0, 2'd2), 1'b1,
                      sa[k], sb[k], sc[k], 1'(ci), "R4 ext left");
            end
        end
        // carry input ignored without extended mode
        do_op(mk(8'h42, 1'b0, 1'b0, 3'b000, 2'd0, 2'd0, 2'd0, 2'd0), 1'b1,
              32'h10, 32'h20, 32'h30, 1'b1, "R4 no ext");

        // set flags nonzero, then R10 hold across cc-clear op
        do_op(mk(8'h50, 1'b1, 1'b0, 3'b000, 2'd0, 2'd0, 2'd0, 2'd0), 1'b1,
              32'h7fffffff, 32'h1, 32'h80000000, 1'b0, "R9 both");
        do_op(mk(8'h51, 1'b0, 1'b0, 3'b000, 2'd0, 2'd0, 2'd0, 2'd0), 1'b1,
              32'h0, 32'h0, 32'h0, 1'b0, "R10 cc clear");

        // R11: illegal combinations keep flags
        do_op(mk(8'h60, 1'b0, 1'b1, 3'b000, 2'd1, 2'd0, 2'd0, 2'd0), 1'b1,
              32'h1, 32'h2, 32'h3, 1'b1, "R11 ext+right");
        do_op(mk(8'h61, 1'b1, 1'b1, 3'b000, 2'd0, 2'd0, 2'd0, 2'd0), 1'b1,
              32'h0, 32'h0, 32'h0, 1'b0, "R11 ext+cc");
        do_op(mk(8'h61, 1'b1, 1'b1, 3'b000, 2'd0, 2'd0, 2'd0, 2'd0), 1'b0,
              32'h0, 32'h0, 32'h0, 1'b0, "R11 ext+cc other form");
        do_op(mk(8'h62, 1'b1, 1'b0, 3'b000, 2'd3, 2'd0, 2'd0, 2'd0), 1'b1,
              32'h0, 32'h0, 32'h0, 1'b0, "R11 shift 3");
        for (int i = 0; i < 3; i++) begin
            do_op(mk(8'h63, 1'b1, 1'b0, 3'b000, 2'd0, (i == 0) ? 2'd3 : 2'd0,
                     (i == 1) ? 2'd3 : 2'd0, (i == 2) ? 2'd3 : 2'd0), 1'b1,
                  32'h0, 32'h0, 32'h0, 1'b0, "R11 half 3");
        end

        // R7: non-register form ignores shift and half bits
        do_op(mk(8'h70, 1'b1, 1'b0, 3'b000, 2'd3, 2'd3, 2'd3, 2'd3), 1'b0,
              32'h12345678, 32'h11111111, 32'h01010101, 1'b0, "R7 junk ignored");
        do_op(mk(8'h71, 1'b1, 1'b0, 3'b010, 2'd1, 2'd1, 2'd2, 2'd1), 1'b0,
              32'hffff0000, 32'h0000ffff, 32'h00010000, 1'b0, "R7 plain sum");

        // R12: idle cycle drops out_valid
        @(negedge clk);
        chk("R12 idle", {63'd0, out_valid}, 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule